// File: doc/BRIEF.md
# Four-Way Combined Multiplicative Uniform Generator

This block produces uniform pseudorandom fractions in [0, 1). It keeps four independent multiplicative congruential components, each with a modulus just under 2^24 and a small multiplier. Every sample advances each component once and adds the four normalised states together, keeping only the fractional part.

Software loads each component separately. A load carries the modulus, the multiplier, the two precomputed factoring constants, a reciprocal of the modulus and the starting state. Loading a different set of modulus and multiplier pairs selects a different substream.

The arithmetic runs on one shared, multi-cycle datapath. The components are handled one after another. The modular product is formed by approximate factoring with a sign fix-up, so no intermediate value needs double width. A start/ready handshake begins one pass, and a one-cycle valid pulse presents the finished 24-bit fraction.

Top module: `urng_quad_mcg`

## Requirements
- R1: Each sample advances every component k as x_k <- (c_k * x_k) mod m_k, exactly once, and the new states carry into the next sample. Moduli lie in 16718909..16776971 and multipliers in 112..127.
- R2: The sample equals the sum over k = 0..3 of term_k, modulo 2^24. Here term_k = floor(x_k * P_k / 2^24), x_k is the freshly advanced state and P_k is the loaded reciprocal, intended to be floor(2^48 / m_k).
- R3: The modular product is computed from the loaded constants q_k = floor(m_k/c_k) and s_k = m_k mod c_k as c_k*(x mod q_k) - s_k*floor(x/q_k), plus m_k when that value is negative. Every written state is nonzero and below m_k, including for start states 1 and m_k-1.
- R4: out_valid rises exactly 40 clock cycles (four components times ten cycles each) after the edge that accepts start, and stays high for one cycle only.
- R5: ready is high only when the datapath is idle and all four components hold a nonzero state. It drops on the cycle after start is accepted and is high again when out_valid is high.
- R6: start while ready is low has no effect: no valid pulse follows, and no component state advances.
- R7: A load with a zero starting state is rejected. cfg_err goes high and ready stays low until that component is reloaded with a nonzero state, which clears cfg_err.
- R8: cfg_we while a pass is in progress is ignored. Parameters and states stay as they were.
- R9: After reset, ready, out_valid and cfg_err are low and every component counts as unloaded.
- R10: out_frac changes only on the cycle out_valid is high and holds its value between samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load one component (ignored while busy) |
| cfg_idx | input | 2 | Component being loaded |
| cfg_mod | input | 24 | Modulus m |
| cfg_mul | input | 7 | Multiplier c |
| cfg_quo | input | 18 | Precomputed floor(m/c) |
| cfg_rem | input | 7 | Precomputed m mod c |
| cfg_rcp | input | 25 | Reciprocal floor(2^48/m) |
| cfg_seed | input | 24 | Starting state, must be nonzero |
| cfg_err | output | 1 | A component holds a rejected zero state |
| start | input | 1 | Request one sample |
| ready | output | 1 | Idle with all components loaded |
| out_valid | output | 1 | One-cycle pulse with a new sample |
| out_frac | output | 24 | Unsigned fraction, value/2^24 |

## Verification
The bench sweeps eight substreams of multipliers and moduli across the legal range. It starts the states at 1, at m-1 and at scattered values, so the negative fix-up path is taken often. A missing fix-up or a swapped factoring constant would produce states that drift from the arithmetic model within a sample or two. A term summed with carry past bit 23 would give fractions outside the modulo-2^24 value.

A poke on the load port in the middle of a pass must leave the following samples unchanged. A start issued while the block is not ready must not advance any state; a design that got this wrong would shift the whole sequence by one step. The zero-state rejection and its recovery are checked at the ports, as are the exact 40-cycle latency and the one-cycle valid width.

// File: rtl/urng_pkg.sv
package urng_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_DIV  = 2'd1,
      PH_MUL  = 2'd2,
      PH_ACC  = 2'd3
   } urng_phase_e;
endpackage

// File: rtl/urng_cfg_bank.sv
module urng_cfg_bank #(
   parameter int NCOMP = 4,
   parameter int X_W   = 24,
   parameter int MUL_W = 7,
   parameter int Q_W   = 18,
   parameter int REM_W = 7,
   parameter int RCP_W = 25,
   localparam int IDX_W = (NCOMP > 1) ? $clog2(NCOMP) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       load_en,
   input  logic [IDX_W-1:0]           load_idx,
   input  logic [X_W-1:0]             load_mod,
   input  logic [MUL_W-1:0]           load_mul,
   input  logic [Q_W-1:0]             load_quo,
   input  logic [REM_W-1:0]           load_rem,
   input  logic [RCP_W-1:0]           load_rcp,
   input  logic [X_W-1:0]             load_seed,
   input  logic                       st_wr_en,
   input  logic [IDX_W-1:0]           st_wr_idx,
   input  logic [X_W-1:0]             st_wr_val,
   input  logic [IDX_W-1:0]           rd_idx,
   output logic [X_W-1:0]             rd_mod,
   output logic [MUL_W-1:0]           rd_mul,
   output logic [Q_W-1:0]             rd_quo,
   output logic [REM_W-1:0]           rd_rem,
   output logic [RCP_W-1:0]           rd_rcp,
   output logic [NCOMP-1:0][X_W-1:0]  x_all,
   output logic                       all_ok,
   output logic                       any_err
);
   logic [NCOMP-1:0][X_W-1:0]   mod_v;
   logic [NCOMP-1:0][MUL_W-1:0] mul_v;
   logic [NCOMP-1:0][Q_W-1:0]   quo_v;
   logic [NCOMP-1:0][REM_W-1:0] rem_v;
   logic [NCOMP-1:0][RCP_W-1:0] rcp_v;
   logic [NCOMP-1:0]            ok_v;
   logic [NCOMP-1:0]            bad_v;

   for (genvar k = 0; k < NCOMP; k++) begin : g_comp
      logic [X_W-1:0]   mod_r;
      logic [MUL_W-1:0] mul_r;
      logic [Q_W-1:0]   quo_r;
      logic [REM_W-1:0] rem_r;
      logic [RCP_W-1:0] rcp_r;
      logic [X_W-1:0]   x_r;
      logic             ok_r;
      logic             bad_r;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mod_r <= '0;
            mul_r <= '0;
            quo_r <= '0;
            rem_r <= '0;
            rcp_r <= '0;
            x_r   <= '0;
            ok_r  <= 1'b0;
            bad_r <= 1'b0;
         end else if (load_en && load_idx == IDX_W'(k)) begin
            mod_r <= load_mod;
            mul_r <= load_mul;
            quo_r <= load_quo;
            rem_r <= load_rem;
            rcp_r <= load_rcp;
            x_r   <= load_seed;
            ok_r  <= (load_seed != '0);
            bad_r <= (load_seed == '0);
         end else if (st_wr_en && st_wr_idx == IDX_W'(k)) begin
            x_r <= st_wr_val;
         end
      end

      assign mod_v[k] = mod_r;
      assign mul_v[k] = mul_r;
      assign quo_v[k] = quo_r;
      assign rem_v[k] = rem_r;
      assign rcp_v[k] = rcp_r;
      assign x_all[k] = x_r;
      assign ok_v[k]  = ok_r;
      assign bad_v[k] = bad_r;
   end

   assign rd_mod  = mod_v[rd_idx];
   assign rd_mul  = mul_v[rd_idx];
   assign rd_quo  = quo_v[rd_idx];
   assign rd_rem  = rem_v[rd_idx];
   assign rd_rcp  = rcp_v[rd_idx];
   assign all_ok  = &ok_v;
   assign any_err = |bad_v;
endmodule

// File: rtl/urng_div_step.sv
module urng_div_step #(
   parameter int X_W   = 24,
   parameter int Q_W   = 18,
   parameter int QUO_W = 8,
   localparam int BN_W = $clog2(QUO_W),
   localparam int DW   = ((Q_W + QUO_W) > X_W) ? (Q_W + QUO_W) : X_W
) (
   input  logic [X_W-1:0]   pr,
   input  logic [QUO_W-1:0] quo,
   input  logic [Q_W-1:0]   q,
   input  logic [BN_W-1:0]  bitn,
   output logic [X_W-1:0]   pr_nxt,
   output logic [QUO_W-1:0] quo_nxt
);
   logic [DW-1:0] q_sh;
   logic [DW-1:0] pr_x;

   always_comb begin
      q_sh    = DW'(q) << bitn;
      pr_x    = DW'(pr);
      pr_nxt  = pr;
      quo_nxt = quo;
      if (pr_x >= q_sh) begin
         pr_nxt        = X_W'(pr_x - q_sh);
         quo_nxt[bitn] = 1'b1;
      end
   end
endmodule

// File: rtl/urng_mulmod_fix.sv
module urng_mulmod_fix #(
   parameter int X_W   = 24,
   parameter int MUL_W = 7,
   parameter int REM_W = 7,
   parameter int QUO_W = 8,
   localparam int P1_W = MUL_W + X_W,
   localparam int P2_W = REM_W + QUO_W,
   localparam int PM_W = (P1_W > P2_W) ? P1_W : P2_W,
   localparam int T_W  = ((PM_W > X_W) ? PM_W : X_W) + 1
) (
   input  logic [X_W-1:0]   rem_x,
   input  logic [QUO_W-1:0] div_x,
   input  logic [MUL_W-1:0] mul,
   input  logic [REM_W-1:0] rem,
   input  logic [X_W-1:0]   modulus,
   output logic [X_W-1:0]   nxt
);
   logic [T_W-1:0] p_hi;
   logic [T_W-1:0] p_lo;
   logic [T_W-1:0] diff;
   logic [T_W-1:0] wrap;

   always_comb begin
      p_hi = T_W'(mul) * T_W'(rem_x);
      p_lo = T_W'(rem) * T_W'(div_x);
      diff = p_hi - p_lo;
      wrap = diff + T_W'(modulus);
      nxt  = diff[T_W-1] ? wrap[X_W-1:0] : diff[X_W-1:0];
   end
endmodule

// File: rtl/urng_frac_term.sv
module urng_frac_term #(
   parameter int X_W    = 24,
   parameter int RCP_W  = 25,
   parameter int FRAC_W = 24,
   localparam int PR_W  = X_W + RCP_W
) (
   input  logic [X_W-1:0]    x,
   input  logic [RCP_W-1:0]  rcp,
   output logic [FRAC_W-1:0] term
);
   logic [PR_W-1:0] prod;

   assign prod = PR_W'(x) * PR_W'(rcp);
   assign term = prod[X_W +: FRAC_W];
endmodule

// File: rtl/urng_quad_mcg.sv
module urng_quad_mcg
   import urng_pkg::*;
#(
   parameter int NCOMP  = 4,
   parameter int X_W    = 24,
   parameter int MUL_W  = 7,
   parameter int Q_W    = 18,
   parameter int REM_W  = 7,
   parameter int QUO_W  = 8,
   parameter int RCP_W  = 25,
   parameter int FRAC_W = 24,
   localparam int IDX_W = (NCOMP > 1) ? $clog2(NCOMP) : 1,
   localparam int BN_W  = $clog2(QUO_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [X_W-1:0]    cfg_mod,
   input  logic [MUL_W-1:0]  cfg_mul,
   input  logic [Q_W-1:0]    cfg_quo,
   input  logic [REM_W-1:0]  cfg_rem,
   input  logic [RCP_W-1:0]  cfg_rcp,
   input  logic [X_W-1:0]    cfg_seed,
   output logic              cfg_err,
   input  logic              start,
   output logic              ready,
   output logic              out_valid,
   output logic [FRAC_W-1:0] out_frac
);
   if (NCOMP < 2 || (NCOMP & (NCOMP - 1)) != 0) begin : g_bad_ncomp
      $error("NCOMP must be a power of two of at least 2");
   end
   if (QUO_W < 2 || (QUO_W & (QUO_W - 1)) != 0) begin : g_bad_quo
      $error("QUO_W must be a power of two of at least 2");
   end
   if (FRAC_W > RCP_W) begin : g_bad_frac
      $error("FRAC_W may not exceed RCP_W");
   end
   if (Q_W + QUO_W <= X_W) begin : g_bad_div
      $error("Q_W + QUO_W must exceed X_W");
   end

   urng_phase_e               phase;
   logic [IDX_W-1:0]          comp_idx;
   logic [BN_W-1:0]           bit_cnt;
   logic [X_W-1:0]            pr;
   logic [X_W-1:0]            pr_nxt;
   logic [QUO_W-1:0]          quo;
   logic [QUO_W-1:0]          quo_nxt;
   logic [X_W-1:0]            xnew_r;
   logic [FRAC_W-1:0]         acc;
   logic [FRAC_W-1:0]         term;
   logic [FRAC_W-1:0]         out_frac_r;
   logic                      out_valid_r;

   logic [X_W-1:0]            rd_mod;
   logic [MUL_W-1:0]          rd_mul;
   logic [Q_W-1:0]            rd_quo;
   logic [REM_W-1:0]          rd_rem;
   logic [RCP_W-1:0]          rd_rcp;
   logic [NCOMP-1:0][X_W-1:0] x_all;
   logic                      all_ok;
   logic                      any_err;

   logic                      idle;
   logic                      accept;
   logic                      last_comp;
   logic                      st_wr_en;
   logic [X_W-1:0]            st_wr_val;
   logic [IDX_W-1:0]          comp_inc;

   assign idle      = (phase == PH_IDLE);
   assign ready     = idle && all_ok && !any_err;
   assign accept    = start && ready;
   assign last_comp = (comp_idx == IDX_W'(NCOMP - 1));
   assign st_wr_en  = (phase == PH_MUL);
   assign comp_inc  = comp_idx + 1'b1;

   urng_cfg_bank #(
      .NCOMP(NCOMP), .X_W(X_W), .MUL_W(MUL_W), .Q_W(Q_W),
      .REM_W(REM_W), .RCP_W(RCP_W)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (cfg_we && idle),
      .load_idx  (cfg_idx),
      .load_mod  (cfg_mod),
      .load_mul  (cfg_mul),
      .load_quo  (cfg_quo),
      .load_rem  (cfg_rem),
      .load_rcp  (cfg_rcp),
      .load_seed (cfg_seed),
      .st_wr_en  (st_wr_en),
      .st_wr_idx (comp_idx),
      .st_wr_val (st_wr_val),
      .rd_idx    (comp_idx),
      .rd_mod    (rd_mod),
      .rd_mul    (rd_mul),
      .rd_quo    (rd_quo),
      .rd_rem    (rd_rem),
      .rd_rcp    (rd_rcp),
      .x_all     (x_all),
      .all_ok    (all_ok),
      .any_err   (any_err)
   );

   urng_div_step #(.X_W(X_W), .Q_W(Q_W), .QUO_W(QUO_W)) u_div (
      .pr      (pr),
      .quo     (quo),
      .q       (rd_quo),
      .bitn    (bit_cnt),
      .pr_nxt  (pr_nxt),
      .quo_nxt (quo_nxt)
   );

   urng_mulmod_fix #(.X_W(X_W), .MUL_W(MUL_W), .REM_W(REM_W), .QUO_W(QUO_W)) u_mm (
      .rem_x   (pr),
      .div_x   (quo),
      .mul     (rd_mul),
      .rem     (rd_rem),
      .modulus (rd_mod),
      .nxt     (st_wr_val)
   );

   urng_frac_term #(.X_W(X_W), .RCP_W(RCP_W), .FRAC_W(FRAC_W)) u_term (
      .x    (xnew_r),
      .rcp  (rd_rcp),
      .term (term)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase       <= PH_IDLE;
         comp_idx    <= '0;
         bit_cnt     <= '0;
         pr          <= '0;
         quo         <= '0;
         xnew_r      <= '0;
         acc         <= '0;
         out_frac_r  <= '0;
         out_valid_r <= 1'b0;
      end else begin
         out_valid_r <= 1'b0;
         case (phase)
            PH_IDLE: begin
               if (accept) begin
                  phase    <= PH_DIV;
                  comp_idx <= '0;
                  pr       <= x_all[0];
                  quo      <= '0;
                  bit_cnt  <= BN_W'(QUO_W - 1);
                  acc      <= '0;
               end
            end
            PH_DIV: begin
               pr  <= pr_nxt;
               quo <= quo_nxt;
               if (bit_cnt == '0) begin
                  phase <= PH_MUL;
               end else begin
                  bit_cnt <= bit_cnt - 1'b1;
               end
            end
            PH_MUL: begin
               xnew_r <= st_wr_val;
               phase  <= PH_ACC;
            end
            PH_ACC: begin
               if (last_comp) begin
                  out_frac_r  <= acc + term;
                  out_valid_r <= 1'b1;
                  comp_idx    <= '0;
                  phase       <= PH_IDLE;
               end else begin
                  acc      <= acc + term;
                  comp_idx <= comp_inc;
                  pr       <= x_all[comp_inc];
                  quo      <= '0;
                  bit_cnt  <= BN_W'(QUO_W - 1);
                  phase    <= PH_DIV;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign out_valid = out_valid_r;
   assign out_frac  = out_frac_r;
   assign cfg_err   = any_err;
endmodule

// File: rtl/urng_quad_mcg_chk.sv
module urng_quad_mcg_chk #(
   parameter int X_W    = 24,
   parameter int FRAC_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              ready,
   input logic              cfg_err,
   input logic              out_valid,
   input logic [FRAC_W-1:0] out_frac,
   input logic              st_wr_en,
   input logic [X_W-1:0]    st_wr_val,
   input logic [X_W-1:0]    rd_mod
);
   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);                                     // R4
   AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      (start && ready) |=> !ready);                                  // R5
   AST_READY_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ready);                                          // R5
   AST_ERR_BLOCKS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !ready);                                           // R7
   AST_FRAC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_frac));                             // R10
   AST_STATE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      st_wr_en |-> (st_wr_val < rd_mod) && (st_wr_val != '0));       // R3
endmodule

bind urng_quad_mcg urng_quad_mcg_chk #(.X_W(X_W), .FRAC_W(FRAC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .ready     (ready),
   .cfg_err   (cfg_err),
   .out_valid (out_valid),
   .out_frac  (out_frac),
   .st_wr_en  (st_wr_en),
   .st_wr_val (st_wr_val),
   .rd_mod    (rd_mod)
);

// File: tb/urng_quad_mcg_test.sv
`timescale 1ns/1ps
module urng_quad_mcg_test;
   localparam int LAT = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_idx = '0;
   logic [23:0] cfg_mod = '0;
   logic [6:0]  cfg_mul = '0;
   logic [17:0] cfg_quo = '0;
   logic [6:0]  cfg_rem = '0;
   logic [24:0] cfg_rcp = '0;
   logic [23:0] cfg_seed = '0;
   logic        cfg_err;
   logic        start = 1'b0;
   logic        ready;
   logic        out_valid;
   logic [23:0] out_frac;

   int checks = 0;
   int errs = 0;

   longint unsigned bm[4];
   longint unsigned ba[4];
   longint unsigned bx[4];
   longint unsigned brcp[4];

   always #2 clk = ~clk;

   urng_quad_mcg uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_mod(cfg_mod), .cfg_mul(cfg_mul), .cfg_quo(cfg_quo),
      .cfg_rem(cfg_rem), .cfg_rcp(cfg_rcp), .cfg_seed(cfg_seed),
      .cfg_err(cfg_err), .start(start), .ready(ready),
      .out_valid(out_valid), .out_frac(out_frac)
   );

   task automatic chk(input bit ok, input string req, input longint unsigned act,
                      input longint unsigned exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive_load(input int idx, input longint unsigned m,
                             input longint unsigned a, input longint unsigned seed);
      @(negedge clk);
      cfg_we   = 1'b1;
      cfg_idx  = 2'(idx);
      cfg_mod  = 24'(m);
      cfg_mul  = 7'(a);
      cfg_quo  = 18'(m / a);
      cfg_rem  = 7'(m % a);
      cfg_rcp  = 25'((64'd1 << 48) / m);
      cfg_seed = 24'(seed);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic load(input int idx, input longint unsigned m,
                       input longint unsigned a, input longint unsigned seed);
      drive_load(idx, m, a, seed);
      bm[idx]   = m;
      ba[idx]   = a;
      bx[idx]   = seed;
      brcp[idx] = (64'd1 << 48) / m;
   endtask

   // Arithmetic model of R1 and R2
   function automatic longint unsigned model_step();
      longint unsigned sum = 0;
      for (int k = 0; k < 4; k++) begin
         bx[k] = (ba[k] * bx[k]) % bm[k];
         sum   = (sum + ((bx[k] * brcp[k]) >> 24)) & 64'hFFFFFF;
      end
      return sum;
   endfunction

   task automatic run_sample(input bit poke);
      int cnt = 0;
      bit seen = 1'b0;
      longint unsigned exp;
      @(negedge clk);
      chk(ready == 1'b1, "R5 ready before start", 64'(ready), 1);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      chk(ready == 1'b0, "R5 busy after accept", 64'(ready), 0);
      for (int i = 1; i <= 80 && !seen; i++) begin
         @(posedge clk);
         @(negedge clk);
         cnt = i;
         if (poke && i == 10) begin
            cfg_we = 1'b1; cfg_idx = 2'd0; cfg_mod = 24'd16720001;
            cfg_mul = 7'd120; cfg_quo = 18'd139333; cfg_rem = 7'd41;
            cfg_rcp = 25'd16837000; cfg_seed = 24'd5;
         end
         if (poke && i == 11) cfg_we = 1'b0;
         if (out_valid) seen = 1'b1;
      end
      exp = model_step();
      chk(seen && cnt == LAT, "R4 latency", 64'(cnt), LAT);
      chk(out_frac == 24'(exp), poke ? "R8 R1 R2 R3 sample" : "R1 R2 R3 sample",
          64'(out_frac), exp);
      @(negedge clk);
      chk(out_valid == 1'b0, "R4 single-cycle valid", 64'(out_valid), 0);
      chk(out_frac == 24'(exp), "R10 frac held", 64'(out_frac), exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      chk(ready == 1'b0, "R9 ready in reset", 64'(ready), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ready == 1'b0, "R9 ready after reset", 64'(ready), 0);
      chk(out_valid == 1'b0, "R9 valid after reset", 64'(out_valid), 0);
      chk(cfg_err == 1'b0, "R9 err after reset", 64'(cfg_err), 0);

      // R6: start with nothing loaded
      begin
         bit any_v = 1'b0;
         start = 1'b1;
         for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (i == 4) start = 1'b0;
            if (out_valid) any_v = 1'b1;
         end
         chk(any_v == 1'b0, "R6 no valid when not ready", 64'(any_v), 0);
      end

      load(0, 16718909, 112, 7);
      load(1, 16776971, 127, 123456);
      load(2, 16750001, 119, 16000000);
      @(negedge clk);
      chk(ready == 1'b0, "R5 not ready with one unloaded", 64'(ready), 0);
      load(3, 16740017, 115, 0);
      @(negedge clk);
      chk(cfg_err == 1'b1, "R7 zero state flagged", 64'(cfg_err), 1);
      chk(ready == 1'b0, "R7 zero state holds not-ready", 64'(ready), 0);

      // R6: start while ready is low must not advance any state
      begin
         bit any_v = 1'b0;
         start = 1'b1;
         for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (i == 2) start = 1'b0;
            if (out_valid) any_v = 1'b1;
         end
         chk(any_v == 1'b0, "R6 no valid while err", 64'(any_v), 0);
      end

      load(3, 16740017, 115, 999);
      @(negedge clk);
      chk(cfg_err == 1'b0, "R7 reload clears err", 64'(cfg_err), 0);
      chk(ready == 1'b1, "R5 R7 ready after reload", 64'(ready), 1);
      run_sample(1'b0);  // first sample from loaded states also covers R6
      run_sample(1'b0);

      // R8: load in the middle of a pass is ignored
      run_sample(1'b1);
      run_sample(1'b0);

      // Sweep substreams across multiplier and modulus ranges (R1 R2 R3)
      for (int s = 0; s < 8; s++) begin
         for (int k = 0; k < 4; k++) begin
            longint unsigned m = 16718909 + ((s * 9973 + k * 14011) % 58063);
            longint unsigned a = 112 + ((s * 5 + k * 3) % 16);
            longint unsigned sd;
            if (s == 0) sd = 1;
            else if (s == 1) sd = m - 1;
            else sd = 1 + ((s * 1234567 + k * 7654321) % (m - 1));
            load(k, m, a, sd);
         end
         for (int n = 0; n < 12; n++) run_sample(1'b0);
      end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule